// File: doc/BRIEF.md
# Barrel Shift and Bit-Field Extract Unit

This is a 32-bit execution unit for a small soft processor core. It shifts a source operand left, shifts it right with zero fill, or shifts it right with sign fill. In immediate form it can instead pull a right-aligned bit field out of the operand. The shift amount comes from the low five bits of the second operand, which is either a register value or a sign-extended immediate. In extract mode, the 16-bit immediate field supplies the field width and the start offset.

The unit takes a request on a valid strobe and answers one clock later with a registered result and one of three outcomes. A valid result is the normal case. An extract whose width and offset are undefined raises a bad-field flag and writes nothing. When exceptions are enabled, the illegal-opcode trap option is set and the shifter is configured out, the unit raises an illegal-opcode request with its cause code and does not write the register. A request whose destination is register 0 always yields zero.

Top module: `bsx_unit`

## Requirements
- R1: With immediate bit 10 = 1 and extract mode off, the result is operand A shifted left with zero fill.
- R2: With immediate bits 10 = 0 and 9 = 0 and extract mode off, the result is A shifted right with zero fill.
- R3: With immediate bit 10 = 0 and bit 9 = 1 and extract mode off, the result is A shifted right with copies of A's bit 31.
- R4: The shift distance is operand B bits 4:0. Higher bits of B have no effect, and a distance of 0 returns A unchanged.
- R5: Extract mode is active only when the immediate-form input is 1 and immediate bit 14 is 1. In register form, bit 14 is ignored and a shift is performed.
- R6: In extract mode the width is immediate bits 10:6 and the offset is immediate bits 4:0. The result is that field of A, right-aligned and zero-extended. Bits 10 and 9 do not select a shift in this mode.
- R7: An extract with width 0, or with width plus offset greater than 32, sets bad_field for one cycle, keeps res_valid low and drives res to zero. A sum of exactly 32 is legal.
- R8: When exc_en, trap_illegal and a cleared has_shifter are all true on a request, illegal_req pulses with exc_cause = 1, res_valid stays low, and res keeps its previous value. If any of the three conditions is false, no trap occurs.
- R9: A request with dst_idx = 0 that completes normally returns res = 0.
- R10: res_valid, bad_field and illegal_req each pulse for exactly the one cycle after an accepted in_valid, are mutually exclusive, and stay low when there is no request.
- R11: During reset and just after it, res, res_valid, bad_field, illegal_req and exc_cause are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| op_a | input | 32 | Source operand |
| op_b | input | 32 | Shift-distance operand (register or sign-extended immediate) |
| imm | input | 16 | Instruction immediate field |
| imm_form | input | 1 | 1 when the instruction is in immediate form |
| dst_idx | input | 5 | Destination register index |
| exc_en | input | 1 | Exceptions enabled |
| has_shifter | input | 1 | Configuration: shifter present |
| trap_illegal | input | 1 | Configuration: trap on illegal opcodes |
| res | output | 32 | Registered result |
| res_valid | output | 1 | Result is defined and should be written |
| bad_field | output | 1 | Undefined extract width/offset |
| illegal_req | output | 1 | Illegal-opcode exception request |
| exc_cause | output | 5 | Exception cause code (1 = illegal operation) |

## Verification
The hardest cases to reach are the extract boundaries. A width plus offset of exactly 32 must still give a result, while a sum of 33 or a width of 0 must not. A width of 16 or more also sets immediate bit 10, which would select a left shift outside extract mode. The vector table therefore includes immediates with width 31, width 4 at offset 28, width 1 at offset 31, and the two neighbouring illegal encodings. The same bit-14 immediate is also sent in register form to show that it then shifts. Directed requests then toggle each of the three trap conditions on its own, and check a destination of register 0.

// File: rtl/bsx_pkg.sv
package bsx_pkg;
    localparam int unsigned DW = 32;
    localparam int unsigned AW = $clog2(DW);
    localparam int unsigned IW = 16;
    localparam int unsigned CW = 5;
    localparam int unsigned EXT_BIT = 14;
    localparam int unsigned DIR_BIT = 10;
    localparam int unsigned ARI_BIT = 9;
    localparam int unsigned FW_LSB = 6;
    localparam int unsigned FO_LSB = 0;
    localparam logic [CW-1:0] CAUSE_ILLEGAL = CW'(1);

    typedef struct packed {
        logic          ext;
        logic          left;
        logic          arith;
        logic [AW-1:0] amt;
        logic [AW-1:0] fw;
        logic [AW-1:0] fo;
        logic          bad;
        logic          trap;
    } ctrl_t;

    typedef struct packed {
        logic [DW-1:0] res;
        logic          valid;
        logic          bad;
        logic          ill;
        logic [CW-1:0] cause;
    } state_t;
endpackage

// File: rtl/bsx_decode.sv
module bsx_decode
    import bsx_pkg::*;
(
    input  logic [IW-1:0] imm,
    input  logic [DW-1:0] op_b,
    input  logic          imm_form,
    input  logic          exc_en,
    input  logic          has_shifter,
    input  logic          trap_illegal,
    output ctrl_t         ctrl
);
    logic [AW:0] span;

    always_comb begin
        ctrl       = '0;
        ctrl.ext   = imm_form & imm[EXT_BIT];
        ctrl.left  = imm[DIR_BIT];
        ctrl.arith = imm[ARI_BIT];
        ctrl.amt   = op_b[AW-1:0];
        ctrl.fw    = imm[FW_LSB +: AW];
        ctrl.fo    = imm[FO_LSB +: AW];
        span       = {1'b0, ctrl.fw} + {1'b0, ctrl.fo};
        ctrl.bad   = ctrl.ext & ((ctrl.fw == '0) | (span > (AW+1)'(DW)));
        ctrl.trap  = exc_en & trap_illegal & ~has_shifter;
    end
endmodule

// File: rtl/bsx_shift.sv
module bsx_shift
    import bsx_pkg::*;
(
    input  logic [DW-1:0] din,
    input  logic [AW-1:0] amt,
    input  logic          left,
    input  logic          arith,
    output logic [DW-1:0] dout
);
    logic [DW-1:0] stg [AW+1];
    logic [DW-1:0] src;
    logic          fill;

    always_comb begin
        fill = arith & ~left & din[DW-1];
        for (int i = 0; i < DW; i++) begin
            src[i] = left ? din[DW-1-i] : din[i];
        end
    end

    assign stg[0] = src;

    for (genvar k = 0; k < AW; k++) begin : g_stage
        localparam int unsigned STEP = 1 << k;
        assign stg[k+1] = amt[k] ? {{STEP{fill}}, stg[k][DW-1:STEP]} : stg[k];
    end

    always_comb begin
        for (int i = 0; i < DW; i++) begin
            dout[i] = left ? stg[AW][DW-1-i] : stg[AW][i];
        end
    end

    // R4: a zero distance passes the operand through the stage network
    always_comb begin
        if (amt == '0) begin
            a_r4_zero_passthru: assert (dout == din);
        end
    end
endmodule

// File: rtl/bsx_field.sv
module bsx_field
    import bsx_pkg::*;
(
    input  logic [DW-1:0] din,
    input  logic [AW-1:0] fw,
    input  logic [AW-1:0] fo,
    output logic [DW-1:0] dout
);
    logic [DW-1:0] mask;

    always_comb begin
        mask = ~({DW{1'b1}} << fw);
        dout = (din >> fo) & mask;
    end
endmodule

// File: rtl/bsx_unit.sv
module bsx_unit
    import bsx_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [31:0]   op_a,
    input  logic [31:0]   op_b,
    input  logic [15:0]   imm,
    input  logic          imm_form,
    input  logic [4:0]    dst_idx,
    input  logic          exc_en,
    input  logic          has_shifter,
    input  logic          trap_illegal,
    output logic [31:0]   res,
    output logic          res_valid,
    output logic          bad_field,
    output logic          illegal_req,
    output logic [4:0]    exc_cause
);
    ctrl_t         ctrl;
    logic [DW-1:0] shf_out;
    logic [DW-1:0] fld_out;
    state_t        st_d, st_q;

    bsx_decode u_dec (
        .imm          (imm),
        .op_b         (op_b),
        .imm_form     (imm_form),
        .exc_en       (exc_en),
        .has_shifter  (has_shifter),
        .trap_illegal (trap_illegal),
        .ctrl         (ctrl)
    );

    bsx_shift u_shf (
        .din   (op_a),
        .amt   (ctrl.amt),
        .left  (ctrl.left),
        .arith (ctrl.arith),
        .dout  (shf_out)
    );

    bsx_field u_fld (
        .din  (op_a),
        .fw   (ctrl.fw),
        .fo   (ctrl.fo),
        .dout (fld_out)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.bad   = 1'b0;
        st_d.ill   = 1'b0;
        st_d.cause = '0;
        if (in_valid) begin
            if (ctrl.trap) begin
                st_d.ill   = 1'b1;
                st_d.cause = CAUSE_ILLEGAL;
            end else if (ctrl.bad) begin
                st_d.bad = 1'b1;
                st_d.res = '0;
            end else begin
                st_d.valid = 1'b1;
                if (dst_idx == '0) begin
                    st_d.res = '0;
                end else begin
                    st_d.res = ctrl.ext ? fld_out : shf_out;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res         = st_q.res;
    assign res_valid   = st_q.valid;
    assign bad_field   = st_q.bad;
    assign illegal_req = st_q.ill;
    assign exc_cause   = st_q.cause;

    // R10: an outcome pulse only follows an accepted request
    a_r10_pulse_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid || bad_field || illegal_req) |-> $past(in_valid));

    // R10: outcomes are mutually exclusive
    a_r10_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({res_valid, bad_field, illegal_req}) <= 1);

    // R8: a trap request only arises from the three enabling conditions
    a_r8_trap_cause: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_req |-> ($past(exc_en && trap_illegal && !has_shifter) && exc_cause == CAUSE_ILLEGAL));

    // R8: a trap leaves the result untouched
    a_r8_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_req |-> res == $past(res));

    // R9: register zero always reads as zero
    a_r9_zero_dst: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(dst_idx) == 5'd0) |-> res == 32'd0);

    // R7: an undefined extract yields zero
    a_r7_bad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bad_field |-> res == 32'd0);
endmodule

// File: tb/bsx_unit_bench.sv
module bsx_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [15:0] imm = '0;
    logic        imm_form = 1'b0;
    logic [4:0]  dst_idx = 5'd1;
    logic        exc_en = 1'b1;
    logic        has_shifter = 1'b1;
    logic        trap_illegal = 1'b1;
    logic [31:0] res;
    logic        res_valid, bad_field, illegal_req;
    logic [4:0]  exc_cause;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    bsx_unit u_bsx_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .imm(imm), .imm_form(imm_form), .dst_idx(dst_idx), .exc_en(exc_en),
        .has_shifter(has_shifter), .trap_illegal(trap_illegal), .res(res),
        .res_valid(res_valid), .bad_field(bad_field), .illegal_req(illegal_req),
        .exc_cause(exc_cause)
    );

    // {a, b, imm, imm_form, expected result, expected bad_field}
    localparam int NV = 14;
    localparam logic [113:0] VEC [NV] = '{
        {32'h0000_0001, 32'd31,         16'h0400, 1'b0, 32'h8000_0000, 1'b0}, // R1
        {32'h1234_5678, 32'd0,          16'h0400, 1'b0, 32'h1234_5678, 1'b0}, // R4
        {32'h8000_0000, 32'd4,          16'h0000, 1'b0, 32'h0800_0000, 1'b0}, // R2
        {32'h8000_0000, 32'd4,          16'h0200, 1'b0, 32'hF800_0000, 1'b0}, // R3
        {32'h4000_0000, 32'd31,         16'h0200, 1'b0, 32'h0000_0000, 1'b0}, // R3
        {32'h8000_0001, 32'd31,         16'h0200, 1'b0, 32'hFFFF_FFFF, 1'b0}, // R3
        {32'h0000_0001, 32'h0000_0023,  16'h0400, 1'b0, 32'h0000_0008, 1'b0}, // R4
        {32'h0000_0001, 32'd2,          16'h4400, 1'b0, 32'h0000_0004, 1'b0}, // R5
        {32'hABCD_1234, 32'hFFFF_FFFF,  16'h4204, 1'b1, 32'h0000_0023, 1'b0}, // R6
        {32'hABCD_1234, 32'hFFFF_FFFF,  16'h411C, 1'b1, 32'h0000_000A, 1'b0}, // R6
        {32'hFFFF_FFFF, 32'hFFFF_FFFF,  16'h47C1, 1'b1, 32'h7FFF_FFFF, 1'b0}, // R6
        {32'h8000_0000, 32'hFFFF_FFFF,  16'h405F, 1'b1, 32'h0000_0001, 1'b0}, // R6
        {32'hFFFF_FFFF, 32'd0,          16'h4005, 1'b1, 32'h0000_0000, 1'b1}, // R7
        {32'hFFFF_FFFF, 32'd0,          16'h411D, 1'b1, 32'h0000_0000, 1'b1}  // R7
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic issue(input logic [31:0] a, input logic [31:0] b, input logic [15:0] im,
                         input logic frm, input logic [4:0] dst);
        @(negedge clk);
        op_a = a; op_b = b; imm = im; imm_form = frm; dst_idx = dst;
        in_valid = 1'b1;
        @(posedge clk);
        #1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #800000;
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R11 res", res, 32'd0);
        check("R11 strobes", {29'd0, res_valid, bad_field, illegal_req}, 32'd0);
        check("R11 cause", {27'd0, exc_cause}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R11 after reset", {29'd0, res_valid, bad_field, illegal_req}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            op_a = VEC[i][113:82]; op_b = VEC[i][81:50]; imm = VEC[i][49:34];
            imm_form = VEC[i][33]; dst_idx = 5'd3; in_valid = 1'b1;
            @(posedge clk);
            #1;
            check($sformatf("R1-6 vec%0d res", i), res, VEC[i][32:1]);
            check($sformatf("R7 vec%0d bad", i), {31'd0, bad_field}, {31'd0, VEC[i][0]});
            check($sformatf("R10 vec%0d valid", i), {31'd0, res_valid}, {31'd0, ~VEC[i][0]});
            @(negedge clk);
            in_valid = 1'b0;
            @(posedge clk);
            #1;
            check($sformatf("R10 vec%0d idle", i), {29'd0, res_valid, bad_field, illegal_req}, 32'd0);
        end

        // R9: destination zero
        @(negedge clk);
        op_a = 32'hFFFF_0000; op_b = 32'd1; imm = 16'h0400; imm_form = 1'b0;
        dst_idx = 5'd0; in_valid = 1'b1;
        @(posedge clk);
        #1;
        check("R9 res", res, 32'd0);
        check("R9 valid", {31'd0, res_valid}, 32'd1);
        @(negedge clk);
        in_valid = 1'b0;

        // R8: first a normal result, then a trap that must not overwrite it
        @(negedge clk);
        op_a = 32'h0000_00F0; op_b = 32'd4; imm = 16'h0000; dst_idx = 5'd2; in_valid = 1'b1;
        @(posedge clk);
        #1;
        check("R2 before trap", res, 32'h0000_000F);
        @(negedge clk);
        has_shifter = 1'b0; op_a = 32'h1111_1111;
        @(posedge clk);
        #1;
        check("R8 illegal_req", {31'd0, illegal_req}, 32'd1);
        check("R8 cause", {27'd0, exc_cause}, 32'd1);
        check("R8 no valid", {31'd0, res_valid}, 32'd0);
        check("R8 res kept", res, 32'h0000_000F);
        @(negedge clk);
        exc_en = 1'b0;
        @(posedge clk);
        #1;
        check("R8 exc off no trap", {31'd0, illegal_req}, 32'd0);
        check("R8 exc off result", res, 32'h0111_1111);
        @(negedge clk);
        exc_en = 1'b1; trap_illegal = 1'b0;
        @(posedge clk);
        #1;
        check("R8 trap option off", {30'd0, illegal_req, res_valid}, 32'd1);
        @(negedge clk);
        in_valid = 1'b0; trap_illegal = 1'b1; has_shifter = 1'b1;
        @(posedge clk);
        #1;
        check("R10 idle end", {29'd0, res_valid, bad_field, illegal_req}, 32'd0);

        // R5: register form with the extract bit set shifts right instead
        issue(32'h0000_0100, 32'd4, 16'h4204, 1'b0, 5'd1);
        check("R5 register form", res, 32'h0000_0010);

        finish_run();
    end
endmodule